// File: doc/BRIEF.md
# Flash Write-Protection Lock Unit

This block sits between the host bus and a memory-mapped serial flash controller. It judges every host flash request, whether a read, a write or an erase, and answers one clock later with a grant or a deny. Two checks decide the answer. The first is a rights table that lists, for each bus master and each flash region, whether that master may read the region and whether it may modify it. The second is a bank of five address windows. Each window can block all modifying requests that fall inside it, no matter which master sends them.

Configuration goes through a small register port with a write strobe, a 4-bit register index and a 32-bit data word. A sticky lock bit freezes the window registers and the rights table until the next reset. It also shuts the direct-command path: every request flagged as software-sequenced is refused while the lock is set. A board-level override pin removes the rights-table check. The address windows still apply when the pin is asserted. A refused request also raises a sticky error flag, which software clears by writing a 1 to it.

Top module: `flash_wp_filter`

## Requirements
- R1: After reset the lock and error flags read 0, all five window registers read 0 (so every window is off), master 0 reads back `0x0000001F` (may read every region, may modify none) and every other master reads back 0. resp_valid is low.
- R2: Each cycle with req_valid high gives resp_valid high with a valid resp_grant in the next cycle. resp_valid is low after any cycle without a request.
- R3: The top three bits of req_page pick the region. Values 0, 1, 2 and 3 select regions 0 to 3: descriptor, management controller, network controller and platform data. Values 4 to 7 all select region 4, the firmware region.
- R4: For a hardware-sequenced request (req_swseq=0) with the override pin low, a read (req_op=0) is granted only if the master's read bit for the region is set. A modifying request (req_op≠0, write or erase) is granted only if the master's modify bit for the region is set.
- R5: While ovr_pin is high the rights table is not consulted for any request.
- R6: Window k sits at register index k, for k from 0 to 4. Its base page is in bits [11:0], its limit page in bits [27:16] and its enable in bit 31; all other bits read 0. A modifying request whose page p meets base ≤ p ≤ limit for any enabled window is denied, for every master and even with the override pin high. Reads are not affected. A window whose base is above its limit covers nothing.
- R7: Writing 1 to bit 0 of the control register (index 5) sets the lock. Only reset clears it. Writing 0 to that bit has no effect.
- R8: While the lock is set, writes to the window registers (indices 0 to 4) and to the rights registers (indices 8 to 11) are ignored.
- R9: While the lock is set, every request with req_swseq=1 is denied. While the lock is clear, a request with req_swseq=1 skips the rights table but is still subject to the windows.
- R10: Bit 1 of the control register is set in the cycle a deny appears on the outputs. Writing 1 to it clears it. If a clear and a new deny happen in the same cycle, the deny wins.
- R11: Master m's rights sit at register index 8+m, with the read bits per region in [4:0] and the modify bits per region in [12:8]; bit j stands for region j. The control register reads back the lock in bit 0 and the error flag in bit 1. Indices 6, 7 and 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_addr (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 2 | Requesting master ID |
| req_page | input | 12 | Flash address in 4 KB pages |
| req_op | input | 2 | 0 read, any other value modifies (write or erase) |
| req_swseq | input | 1 | Request uses the direct-command path |
| ovr_pin | input | 1 | Board override of the rights table |
| resp_valid | output | 1 | Decision present (one cycle after the request) |
| resp_grant | output | 1 | 1 grant, 0 deny |

## Verification
The hardest situation to reach from the ports is a locked unit that receives software writes trying to change its state. This covers attempts to rewrite a window, to alter a master's rights and to clear the lock. The stimulus first builds a known non-default configuration and runs full request sweeps against it. It then sets the lock and sends each of those forbidden writes. Read-back and a repeated sweep show that nothing changed while direct-command requests are now refused. A further case drives a denied request and an error-clear write into the same clock edge, so that the rule that the deny wins can be seen.

// File: rtl/flash_wp_filter.sv
module flash_wp_filter #(
  parameter int NUM_MASTERS = 4,
  parameter int PAGE_W = 12,
  parameter int HOST_ID = 0,
  localparam int MASTER_W = $clog2(NUM_MASTERS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                req_valid,
  input  logic [MASTER_W-1:0] req_master,
  input  logic [PAGE_W-1:0]   req_page,
  input  logic [1:0]          req_op,
  input  logic                req_swseq,
  input  logic                ovr_pin,
  output logic                resp_valid,
  output logic                resp_grant
);
  localparam int NUM_RNG = 5;
  localparam int NUM_REG = 5;
  localparam logic [3:0] CTRL_IDX = 4'd5;
  localparam int RIGHTS_IDX = 8;
  localparam logic [31:0] FIELD = (32'd1 << PAGE_W) - 32'd1;
  localparam logic [31:0] RNG_MASK = 32'h8000_0000 | (FIELD << 16) | FIELD;

  logic                              lock_q, err_q;
  logic [NUM_RNG-1:0][31:0]          rng_q;
  logic [NUM_MASTERS-1:0][NUM_REG-1:0] rd_q, wr_q;
  logic [NUM_RNG-1:0]                hit;
  logic [2:0]                        slot, region;
  logic                              modify, perm, grant_c;

  wire ctrl_wr = cfg_we && cfg_addr == CTRL_IDX;

  assign slot   = req_page[PAGE_W-1 -: 3];
  assign region = slot[2] ? 3'd4 : slot;
  assign modify = |req_op;
  assign perm   = modify ? wr_q[req_master][region] : rd_q[req_master][region];

  for (genvar i = 0; i < NUM_RNG; i++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rng_q[i] <= '0;
      else if (cfg_we && !lock_q && cfg_addr == 4'(i)) rng_q[i] <= cfg_wdata & RNG_MASK;
    assign hit[i] = rng_q[i][31] && req_page >= rng_q[i][PAGE_W-1:0]
                    && req_page <= rng_q[i][16 +: PAGE_W];
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_rights
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rd_q[m] <= (m == HOST_ID) ? '1 : '0;
        wr_q[m] <= '0;
      end else if (cfg_we && !lock_q && cfg_addr == 4'(RIGHTS_IDX + m)) begin
        rd_q[m] <= cfg_wdata[NUM_REG-1:0];
        wr_q[m] <= cfg_wdata[8 +: NUM_REG];
      end
  end

  assign grant_c = !(req_swseq && lock_q) && (ovr_pin || req_swseq || perm)
                   && !(modify && |hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q     <= 1'b0;
      err_q      <= 1'b0;
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      lock_q     <= lock_q | (ctrl_wr && cfg_wdata[0]);
      resp_valid <= req_valid;
      resp_grant <= req_valid && grant_c;
      if (req_valid && !grant_c) err_q <= 1'b1;
      else if (ctrl_wr && cfg_wdata[1]) err_q <= 1'b0;
    end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_RNG; i++)
      if (cfg_addr == 4'(i)) cfg_rdata = rng_q[i];
    if (cfg_addr == CTRL_IDX) cfg_rdata[1:0] = {err_q, lock_q};
    for (int m = 0; m < NUM_MASTERS; m++)
      if (cfg_addr == 4'(RIGHTS_IDX + m)) begin
        cfg_rdata[NUM_REG-1:0]  = rd_q[m];
        cfg_rdata[8 +: NUM_REG] = wr_q[m];
      end
  end
endmodule

module flash_wp_filter_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_swseq,
  input logic             resp_valid,
  input logic             resp_grant,
  input logic             lock_q,
  input logic             err_q,
  input logic [4:0][31:0] rng_q
);
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_rng_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(rng_q));
  p_swseq_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_swseq && lock_q |=> resp_valid && !resp_grant);
  p_err_on_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_grant |-> err_q);
endmodule

bind flash_wp_filter flash_wp_filter_chk u_chk (.*);

// File: tb/test_flash_wp_filter.sv
`timescale 1ns/1ps
module test_flash_wp_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_swseq = 0, ovr_pin = 0;
  logic [1:0] req_master = 0, req_op = 0;
  logic [11:0] req_page = 0;
  logic resp_valid, resp_grant;

  int nchk = 0, nerr = 0;
  logic [31:0] m_rng [5];
  logic [4:0] m_rd [4], m_wr [4];
  bit m_lock, m_err;
  logic [11:0] pages [19] = '{12'h00F, 12'h010, 12'h015, 12'h01F, 12'h020, 12'h200,
    12'h250, 12'h2FF, 12'h300, 12'h400, 12'h600, 12'h800, 12'h9FF, 12'hA00,
    12'hA01, 12'hC00, 12'hE00, 12'hFFE, 12'hFFF};

  always #2 clk = ~clk;

  flash_wp_filter i_flash_wp_filter (.*);

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_rng[i] = 0;
    for (int m = 0; m < 4; m++) begin m_rd[m] = (m == 0) ? 5'h1F : 5'h0; m_wr[m] = 0; end
    m_lock = 0; m_err = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic wr_cfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 5 && !m_lock) m_rng[a] = d & 32'h8FFF_0FFF;
    if (a == 5) begin
      if (d[0]) m_lock = 1;
      if (d[1]) m_err = 0;
    end
    if (a >= 8 && a <= 11 && !m_lock) begin m_rd[a-8] = d[4:0]; m_wr[a-8] = d[12:8]; end
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(tag, cfg_rdata, exp);
  endtask

  function automatic bit exp_grant(input int m, input logic [11:0] p, input logic [1:0] op, input bit sw);
    int r;
    bit w, ok, hit;
    r = (p[11:9] >= 4) ? 4 : int'(p[11:9]);
    w = (op != 0);
    if (sw && m_lock) return 0;
    ok = ovr_pin || sw || (w ? m_wr[m][r] : m_rd[m][r]);
    hit = 0;
    for (int i = 0; i < 5; i++)
      if (m_rng[i][31] && p >= m_rng[i][11:0] && p <= m_rng[i][27:16]) hit = 1;
    return ok && !(w && hit);
  endfunction

  task automatic do_req(input string tag, input int m, input logic [11:0] p,
                        input logic [1:0] op, input bit sw);
    bit e;
    e = exp_grant(m, p, op, sw);
    @(negedge clk);
    req_valid = 1; req_master = 2'(m); req_page = p; req_op = op; req_swseq = sw;
    @(negedge clk);
    check({tag, " R2 valid"}, {31'b0, resp_valid}, 1);
    check(tag, {31'b0, resp_grant}, {31'b0, e});
    req_valid = 0;
    if (!e) m_err = 1;
  endtask

  task automatic sweep(input string tag, input bit sw);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 19; k++)
        for (int op = 0; op < 3; op++)
          do_req(tag, m, pages[k], 2'(op), sw);
  endtask

  initial begin
    do_reset();
    check("R1 resp_valid idle", {31'b0, resp_valid}, 0);
    for (int i = 0; i < 5; i++) rd_check("R1 window reset", 4'(i), 0);
    rd_check("R1 control reset", 5, 0);
    rd_check("R1 host rights", 8, 32'h1F);
    for (int m = 1; m < 4; m++) rd_check("R1 other rights", 4'(8 + m), 0);
    rd_check("R11 unused 6", 6, 0);
    rd_check("R11 unused 12", 12, 0);

    sweep("R4 R3 default table", 0);
    wr_cfg(9, 32'hFFFF_E615);
    wr_cfg(10, 32'h0000_1F1F);
    rd_check("R11 rights field", 9, 32'h0615);
    rd_check("R11 rights full", 10, 32'h1F1F);
    sweep("R4 R3 hw table", 0);
    ovr_pin = 1;
    sweep("R5 override", 0);
    ovr_pin = 0;

    wr_cfg(0, 32'h801F_0010);
    wr_cfg(1, 32'h02FF_0200);
    wr_cfg(2, 32'h82FF_0300);
    wr_cfg(3, 32'hFFFF_FFFF);
    wr_cfg(4, 32'h8A00_0A00);
    rd_check("R6 window mask", 3, 32'h8FFF_0FFF);
    rd_check("R6 window read", 0, 32'h801F_0010);
    sweep("R6 windows", 0);
    ovr_pin = 1;
    sweep("R6 windows with override", 0);
    ovr_pin = 0;
    sweep("R9 swseq unlocked", 1);

    rd_check("R10 err set", 5, {30'b0, m_err, m_lock});
    wr_cfg(5, 32'h2);
    rd_check("R10 err cleared", 5, 0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5; cfg_wdata = 32'h2;
    req_valid = 1; req_master = 3; req_page = 12'h000; req_op = 0; req_swseq = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R10 deny in clash", {31'b0, resp_grant}, 0);
    rd_check("R10 deny beats clear", 5, 32'h2);
    wr_cfg(5, 32'h2);
    m_err = 0;

    wr_cfg(5, 32'h1);
    rd_check("R7 lock set", 5, 32'h1);
    wr_cfg(5, 32'h0);
    rd_check("R7 lock holds", 5, 32'h1);
    wr_cfg(0, 32'h0);
    rd_check("R8 window frozen", 0, 32'h801F_0010);
    wr_cfg(4, 32'h0);
    rd_check("R8 window4 frozen", 4, 32'h8A00_0A00);
    wr_cfg(11, 32'h1F1F);
    rd_check("R8 rights frozen", 11, 0);
    sweep("R9 swseq locked", 1);
    sweep("R8 hw after lock", 0);

    do_reset();
    rd_check("R7 reset unlocks", 5, 0);
    rd_check("R1 window after reset", 0, 0);
    rd_check("R1 host after reset", 8, 32'h1F);
    rd_check("R1 master1 after reset", 9, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule